// File: doc/BRIEF.md
# High-speed to peripheral bus bridge

This block sits between a pipelined AHB system bus and a simple APB peripheral bus. On the AHB side it is a slave. On the APB side it is the only master. When a transfer selects it, the bridge records the address and the direction during the one-cycle address phase. It then runs a single two-cycle APB access. While that access runs, the bridge holds the system bus in wait states. When the access finishes, the bridge releases the system bus and returns read data for one cycle.

A field of the address picks one of up to four peripheral select lines. Each peripheral has its own read-data bus, and the bridge multiplexes these internally. Read and write data use separate buses on both sides, so there are no tristate nets. Idle and busy transfer codes, unselected cycles and addresses that decode to a missing peripheral cause no peripheral access. Each of these completes at once with an OKAY response.

Top module: `ahb_apb_bridge`

## Requirements
- R1: During and right after reset, and whenever reset is applied in the middle of an access, `psel` is all zero, `penable` is low, `hreadyout` is high and `hresp` is low.
- R2: A transfer is accepted when, in a cycle where `hreadyout` is high, `hsel`, `hready` and `htrans[1]` are all high and the address maps to a peripheral. In the next cycle the bridge is in the setup phase: exactly one `psel` bit is high, `penable` is low and `hreadyout` is low.
- R3: The cycle after the setup phase is the access phase. The same `psel` bit stays high, `penable` is high and `hreadyout` is still low.
- R4: The cycle after the access phase is a completion cycle. `hreadyout` is high, and `psel` and `penable` are low. On a read, `hrdata` holds the selected peripheral's read data as sampled at the end of the access phase.
- R5: `paddr` and `pwrite` equal the `haddr` and `hwrite` values that were accepted. They stay stable, together with `pwdata`, from the setup phase through the access phase.
- R6: On a write, `pwdata` carries the `hwdata` that the master presents in the first data-phase cycle. The peripheral sees exactly one write with that data.
- R7: An `htrans` of IDLE (2'b00) or BUSY (2'b01) starts no access. `hreadyout` stays high, with no wait states.
- R8: A cycle with `hsel` low, or with `hready` low, is ignored and starts no access.
- R9: The peripheral index is `haddr[SLOT_LSB+1:SLOT_LSB]`, which is bits 13:12 by default, and `psel[index]` is the line driven. At most one `psel` bit is ever high. An index at or above `NUM_PERIPH` (3 by default) starts no access and completes with no wait states.
- R10: An address phase accepted during a completion cycle leads directly to a setup phase in the next cycle, with no idle cycle between the two accesses.
- R11: `hresp` is always OKAY (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Bridge selected on the system bus |
| haddr | input | ADDR_W | System bus address |
| htrans | input | 2 | Transfer type; bit 1 marks a real transfer |
| hwrite | input | 1 | 1 = write, 0 = read |
| hwdata | input | DATA_W | System bus write data |
| hready | input | 1 | Bus-wide ready; high when the previous transfer completes |
| hreadyout | output | 1 | Bridge ready; low inserts wait states |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | DATA_W | Read data returned to the system bus |
| paddr | output | ADDR_W | Peripheral address |
| psel | output | NUM_PERIPH | One select line per peripheral |
| penable | output | 1 | High in the access phase |
| pwrite | output | 1 | Peripheral direction |
| pwdata | output | DATA_W | Peripheral write data |
| prdata | input | NUM_PERIPH*DATA_W | Read data from every peripheral, peripheral k in slice k |

## Verification
The bound checker watches properties that hold on every cycle:
- the setup phase is always followed by the access phase,
- the access phase is always followed by a ready cycle,
- at most one `psel` bit is high,
- wait states are only inserted while a select is active,
- the peripheral address, direction and data stay stable during the access phase,
- accepted transfers are registered correctly, and idle or busy codes are rejected.

Only the bench scenarios can show the rest. These cover the returned read values for each peripheral, that exactly one write with the correct data reaches the peripheral, the silent decline of an unmapped index, the ignoring of a cycle with `hready` low, back-to-back transfers, and reset applied in the middle of an access.

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_PERIPH = 3,
  parameter int SLOT_LSB   = 12
) (
  input  logic                         hclk,
  input  logic                         hresetn,
  input  logic                         hsel,
  input  logic [ADDR_W-1:0]            haddr,
  input  logic [1:0]                   htrans,
  input  logic                         hwrite,
  input  logic [DATA_W-1:0]            hwdata,
  input  logic                         hready,
  output logic                         hreadyout,
  output logic                         hresp,
  output logic [DATA_W-1:0]            hrdata,
  output logic [ADDR_W-1:0]            paddr,
  output logic [NUM_PERIPH-1:0]        psel,
  output logic                         penable,
  output logic                         pwrite,
  output logic [DATA_W-1:0]            pwdata,
  input  logic [NUM_PERIPH*DATA_W-1:0] prdata
);

  localparam int SEL_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACCESS, ST_DONE} state_t;

  state_t              state_q, state_d;
  logic [SEL_W-1:0]    req_slot, slot_q;
  logic                req_mapped, can_accept, start, active;
  logic [ADDR_W-1:0]   addr_q;
  logic                write_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q, sel_rdata;

  assign req_slot   = haddr[SLOT_LSB +: SEL_W];
  assign req_mapped = ({1'b0, req_slot} < (SEL_W+1)'(NUM_PERIPH));
  assign can_accept = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign start      = can_accept && hsel && hready && htrans[1] && req_mapped;
  assign active     = (state_q == ST_SETUP) || (state_q == ST_ACCESS);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: state_d = ST_DONE;
      ST_DONE:   state_d = start ? ST_SETUP : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      slot_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (start) begin
        addr_q  <= haddr;
        write_q <= hwrite;
        slot_q  <= req_slot;
      end
      if (state_q == ST_SETUP)  wdata_q <= hwdata;
      if (state_q == ST_ACCESS) rdata_q <= sel_rdata;
    end
  end

  always_comb begin
    sel_rdata = '0;
    for (int i = 0; i < NUM_PERIPH; i++)
      if (slot_q == SEL_W'(i)) sel_rdata = prdata[i*DATA_W +: DATA_W];
  end

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_psel
    assign psel[g] = active && (slot_q == SEL_W'(g));
  end

  assign penable   = (state_q == ST_ACCESS);
  assign paddr     = addr_q;
  assign pwrite    = write_q;
  assign pwdata    = (state_q == ST_SETUP) ? hwdata : wdata_q;
  assign hreadyout = !active;
  assign hresp     = 1'b0;
  assign hrdata    = rdata_q;

endmodule

// File: rtl/ahb_apb_bridge_sva.sv
module ahb_apb_bridge_sva #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_PERIPH = 3,
  parameter int SLOT_LSB   = 12
) (
  input logic                  hclk,
  input logic                  hresetn,
  input logic                  hsel,
  input logic [ADDR_W-1:0]     haddr,
  input logic [1:0]            htrans,
  input logic                  hwrite,
  input logic                  hready,
  input logic                  hreadyout,
  input logic [ADDR_W-1:0]     paddr,
  input logic [NUM_PERIPH-1:0] psel,
  input logic                  penable,
  input logic                  pwrite,
  input logic [DATA_W-1:0]     pwdata
);

  localparam int SEL_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

  logic in_map;
  assign in_map = ({1'b0, haddr[SLOT_LSB +: SEL_W]} < (SEL_W+1)'(NUM_PERIPH));

  assert_accept_R2: assert property (@(posedge hclk) disable iff (!hresetn)
    (hreadyout && hsel && hready && htrans[1] && in_map) |=> (|psel && !penable && !hreadyout));

  assert_wait_has_sel_R2: assert property (@(posedge hclk) disable iff (!hresetn)
    !hreadyout |-> |psel);

  assert_setup_to_access_R3: assert property (@(posedge hclk) disable iff (!hresetn)
    (|psel && !penable) |=> (penable && psel == $past(psel)));

  assert_access_ends_R4: assert property (@(posedge hclk) disable iff (!hresetn)
    penable |=> (hreadyout && !penable));

  assert_capture_R5: assert property (@(posedge hclk) disable iff (!hresetn)
    (|psel && !penable) |-> (paddr == $past(haddr) && pwrite == $past(hwrite)));

  assert_stable_R5: assert property (@(posedge hclk) disable iff (!hresetn)
    penable |-> ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  assert_idle_busy_R7: assert property (@(posedge hclk) disable iff (!hresetn)
    (hreadyout && hsel && hready && !htrans[1]) |=> (!(|psel) && hreadyout));

  assert_single_sel_R9: assert property (@(posedge hclk) disable iff (!hresetn)
    $onehot0(psel));

endmodule

bind ahb_apb_bridge ahb_apb_bridge_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PERIPH(NUM_PERIPH), .SLOT_LSB(SLOT_LSB)
) u_sva (
  .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
  .hwrite(hwrite), .hready(hready), .hreadyout(hreadyout), .paddr(paddr),
  .psel(psel), .penable(penable), .pwrite(pwrite), .pwdata(pwdata)
);

// File: tb/ahb_apb_bridge_tb.sv
module ahb_apb_bridge_tb;
  localparam int AW = 32, DW = 32, NP = 3, LSB = 12;

  typedef struct packed {
    logic        sel;
    logic [1:0]  trans;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        acc;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 2'b10, 1'b1, 32'h0000_0010, 32'hDEAD_BEEF, 1'b1},
    '{1'b1, 2'b10, 1'b0, 32'h0000_1024, 32'h0,         1'b1},
    '{1'b1, 2'b11, 1'b1, 32'h0000_2ABC, 32'h1234_5678, 1'b1},
    '{1'b1, 2'b11, 1'b0, 32'h0000_2FF0, 32'h0,         1'b1},
    '{1'b1, 2'b00, 1'b1, 32'h0000_1000, 32'hAAAA_0000, 1'b0},
    '{1'b1, 2'b01, 1'b0, 32'h0000_0004, 32'h0,         1'b0},
    '{1'b0, 2'b10, 1'b1, 32'h0000_0008, 32'h5555_0000, 1'b0},
    '{1'b1, 2'b10, 1'b1, 32'h0000_3000, 32'h7777_0000, 1'b0},
    '{1'b1, 2'b10, 1'b0, 32'h0000_3004, 32'h0,         1'b0},
    '{1'b1, 2'b10, 1'b0, 32'hFFFF_0ABC, 32'h0,         1'b1}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic hresetn = 1'b0, hsel = 1'b0, hwrite = 1'b0;
  logic [1:0] htrans = 2'b00;
  logic [AW-1:0] haddr = '0;
  logic [DW-1:0] hwdata = '0;
  logic hready, hreadyout, hresp, penable, pwrite;
  logic [DW-1:0] hrdata, pwdata;
  logic [AW-1:0] paddr;
  logic [NP-1:0] psel;
  logic [NP*DW-1:0] prdata;
  logic ovr_en = 1'b0, ovr_val = 1'b1;

  assign hready = ovr_en ? ovr_val : hreadyout;

  for (genvar k = 0; k < NP; k++) begin : g_periph
    assign prdata[k*DW +: DW] = {8'(80 + k), 8'h00, paddr[15:0]};
  end

  ahb_apb_bridge #(.ADDR_W(AW), .DATA_W(DW), .NUM_PERIPH(NP), .SLOT_LSB(LSB)) u_dut (
    .hclk(clk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hwdata(hwdata), .hready(hready), .hreadyout(hreadyout),
    .hresp(hresp), .hrdata(hrdata), .paddr(paddr), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata)
  );

  int wr_cnt = 0;
  logic [DW-1:0] wr_data = '0;
  logic [NP-1:0] wr_sel = '0;
  always @(posedge clk)
    if (hresetn && (|psel) && penable && pwrite) begin
      wr_cnt  <= wr_cnt + 1;
      wr_data <= pwdata;
      wr_sel  <= psel;
    end

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int slot, input logic [31:0] a);
    return {8'(80 + slot), 8'h00, a[15:0]};
  endfunction

  task automatic xfer(input vec_t v, input bit b2b);
    int slot = int'(v.addr[LSB +: 2]);
    int wr_before = wr_cnt;
    logic [NP-1:0] exp_sel = NP'(1) << slot;
    string tag;
    hsel = v.sel; htrans = v.trans; hwrite = v.wr; haddr = v.addr;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwdata = v.wdata;
    if (v.acc) begin
      tag = b2b ? "R10" : "R2";
      chk(tag, "setup psel", 64'(psel), 64'(exp_sel));
      chk(tag, "setup penable", 64'(penable), 64'd0);
      chk(tag, "setup hreadyout", 64'(hreadyout), 64'd0);
      chk("R5", "paddr", 64'(paddr), 64'(v.addr));
      chk("R5", "pwrite", 64'(pwrite), 64'(v.wr));
      @(negedge clk);
      chk("R3", "access penable", 64'(penable), 64'd1);
      chk("R3", "access psel", 64'(psel), 64'(exp_sel));
      chk("R3", "access hreadyout", 64'(hreadyout), 64'd0);
      chk("R5", "access paddr", 64'(paddr), 64'(v.addr));
      if (v.wr) chk("R6", "pwdata", 64'(pwdata), 64'(v.wdata));
      @(negedge clk);
      chk("R4", "done hreadyout", 64'(hreadyout), 64'd1);
      chk("R4", "done psel", 64'(psel), 64'd0);
      chk("R4", "done penable", 64'(penable), 64'd0);
      chk("R11", "hresp", 64'(hresp), 64'd0);
      if (!v.wr) chk("R4", "hrdata", 64'(hrdata), 64'(exp_rd(slot, v.addr)));
      else begin
        chk("R6", "write count", 64'(wr_cnt), 64'(wr_before + 1));
        chk("R6", "write data", 64'(wr_data), 64'(v.wdata));
        chk("R9", "write select", 64'(wr_sel), 64'(exp_sel));
      end
    end else begin
      tag = !v.sel ? "R8" : (!v.trans[1] ? "R7" : "R9");
      chk(tag, "no access psel", 64'(psel), 64'd0);
      chk(tag, "zero wait hreadyout", 64'(hreadyout), 64'd1);
      chk("R11", "hresp", 64'(hresp), 64'd0);
      chk(tag, "no write", 64'(wr_cnt), 64'(wr_before));
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset psel", 64'(psel), 64'd0);
    chk("R1", "reset penable", 64'(penable), 64'd0);
    chk("R1", "reset hreadyout", 64'(hreadyout), 64'd1);
    chk("R1", "reset hresp", 64'(hresp), 64'd0);
    hresetn = 1'b1;
    @(negedge clk);
    chk("R1", "post reset psel", 64'(psel), 64'd0);

    for (int i = 0; i < 10; i++) begin
      xfer(VECS[i], 1'b0);
      @(negedge clk);
    end

    xfer('{1'b1, 2'b10, 1'b1, 32'h0000_1100, 32'hCAFE_0001, 1'b1}, 1'b0);
    xfer('{1'b1, 2'b10, 1'b0, 32'h0000_2200, 32'h0, 1'b1}, 1'b1);
    @(negedge clk);

    ovr_en = 1'b1; ovr_val = 1'b0;
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h0000_1040;
    @(negedge clk);
    chk("R8", "hready low psel", 64'(psel), 64'd0);
    chk("R8", "hready low hreadyout", 64'(hreadyout), 64'd1);
    hsel = 1'b0; htrans = 2'b00; ovr_en = 1'b0;
    @(negedge clk);
    chk("R8", "hready low no later access", 64'(psel), 64'd0);

    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; haddr = 32'h0000_2010;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00;
    @(negedge clk);
    chk("R3", "pre-reset access", 64'(penable), 64'd1);
    hresetn = 1'b0;
    #1;
    chk("R1", "mid reset psel", 64'(psel), 64'd0);
    chk("R1", "mid reset penable", 64'(penable), 64'd0);
    chk("R1", "mid reset hreadyout", 64'(hreadyout), 64'd1);
    @(negedge clk);
    hresetn = 1'b1;
    @(negedge clk);
    chk("R1", "after reset idle", 64'(psel), 64'd0);

    done = 1'b1;
    summary();
  end
endmodule